// File: doc/BRIEF.md
# MDIO Management Master with Status Scan

This block is a host-programmed master for the two-wire PHY management bus (MDC clock, MDIO data). A host writes a clock divisor, a PHY/register address, outgoing data and a command through a small register write port. The block then produces MDC from the system clock and shifts out a complete clause-22 management frame. For a read it releases MDIO at the turnaround and captures the PHY's 16-bit answer.

Besides single writes and reads, the block offers a scan mode. While scan is enabled, it keeps reading the status register of the selected PHY, one frame after another. Each result updates a link-fail flag. A not-valid flag tells the host when the scanned data and link-fail can be trusted. Busy stays asserted until scan has been switched off and the read in flight has finished.

Top module: `mdio_scan_master`

## Requirements
- R1: After reset, busy, scan_invalid, link_fail, mdc and mdio_oe are 0 and rd_data is 0x0000.
- R2: The MDC period is D system clocks, where D is the divisor register (select 0) rounded down to even, with a minimum of 2. MDC stays low while busy is 0.
- R3: A write command (command register at select 1, bit 0) sends 32 ones, then start 01, op 01, the 5-bit PHY address (address register select 2, bits 4:0), the 5-bit register address (bits 12:8), turnaround 10 and the 16-bit data register (select 3), each field MSB first. mdio_oe stays high for the whole frame.
- R4: A read command (bit 1) sends op 10 and drops mdio_oe from the first turnaround bit onward. It samples MDIO on the rising edge of MDC for the 16 data bits and places the word in rd_data at the end of the frame.
- R5: A read from a PHY that does not answer, so that MDIO stays pulled high, returns 0xFFFF.
- R6: While scan (bit 2) is set, the block issues read frames of register 1 at the selected PHY back to back, and each result lands in rd_data.
- R7: After each scan read, link_fail equals the inverse of bit 2 of the word read.
- R8: Setting scan from off raises scan_invalid. It clears when the first scan read completes.
- R9: After scan is cleared in the middle of a frame, busy stays high until that frame ends. No further frame follows.
- R10: A write or read command issued while busy is high is ignored.
- R11: mdio_out and mdio_oe change only when MDC falls or while MDC is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 divisor, 1 command, 2 address, 3 write data |
| cfg_wdata | input | 16 | Register write data |
| mdio_in | input | 1 | MDIO line as seen at the pad |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| rd_data | output | 16 | Last read result |
| busy | output | 1 | Operation pending, in flight, or scan enabled |
| scan_invalid | output | 1 | Scan data and link_fail not yet valid |
| link_fail | output | 1 | Inverse of link-status bit from last scan read |

## Verification
The hardest situation to reach is switching scan off while a status read is partway through its frame. At that point busy must hold, the frame must complete, and no new frame may start. The bench waits on its PHY model's bit counter and clears scan at a fixed bit of a scan frame. It then counts the frames the PHY sees until busy drops. A write command issued during the same scan shows that commands given while busy leave the PHY registers untouched.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int FRAME_BITS = 64;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int PRE_BITS   = 32;
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 5;

    localparam logic [IDX_W-1:0] TA_POS   = IDX_W'(46);
    localparam logic [IDX_W-1:0] DATA_POS = IDX_W'(48);
    localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(FRAME_BITS - 1);

    localparam logic [ADDR_W-1:0] STAT_REG = ADDR_W'(1);
    localparam int LINK_BIT = 2;

    localparam logic [1:0] SEL_DIV  = 2'd0;
    localparam logic [1:0] SEL_CMD  = 2'd1;
    localparam logic [1:0] SEL_ADDR = 2'd2;
    localparam logic [1:0] SEL_TXD  = 2'd3;

    localparam int CMD_WR   = 0;
    localparam int CMD_RD   = 1;
    localparam int CMD_SCAN = 2;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } op_e;

    typedef enum logic [1:0] {
        K_WRITE,
        K_READ,
        K_SCAN
    } kind_e;

    typedef struct packed {
        op_e                op;
        logic [ADDR_W-1:0]  phy;
        logic [ADDR_W-1:0]  regad;
        logic [DATA_W-1:0]  data;
    } frame_req_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(input frame_req_t r);
        logic [1:0] ta;
        ta = (r.op == OP_WRITE) ? 2'b10 : 2'b11;
        return {{PRE_BITS{1'b1}}, 2'b01, r.op, r.phy, r.regad, ta, r.data};
    endfunction

endpackage

// File: rtl/mdc_gen.sv
module mdc_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] even_div;
    logic [DIV_W-1:0] half;
    logic [DIV_W-1:0] cnt;
    logic             tick;

    always_comb begin
        even_div = {div[DIV_W-1:1], 1'b0};
        if (even_div < DIV_W'(2))
            half = DIV_W'(1);
        else
            half = {1'b0, even_div[DIV_W-1:1]};
    end

    assign tick      = run && (cnt >= half - DIV_W'(1));
    assign rise_tick = tick && !mdc;
    assign fall_tick = tick && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  frame_req_t        req,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_in,
    output logic              active,
    output logic              done,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rx_data
);
    logic [FRAME_BITS-1:0] shreg;
    logic [IDX_W-1:0]      bitidx;
    logic                  is_read;

    assign done     = active && fall_tick && (bitidx == LAST_POS);
    assign mdio_out = shreg[FRAME_BITS-1];
    assign mdio_oe  = active && !(is_read && (bitidx >= TA_POS));

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '1;
            bitidx  <= '0;
            is_read <= 1'b0;
            active  <= 1'b0;
            rx_data <= '0;
        end else begin
            if (start && !active) begin
                shreg   <= build_frame(req);
                bitidx  <= '0;
                is_read <= (req.op == OP_READ);
                active  <= 1'b1;
            end
            if (active && rise_tick && is_read && (bitidx >= DATA_POS))
                rx_data <= {rx_data[DATA_W-2:0], mdio_in};
            if (active && fall_tick) begin
                if (bitidx == LAST_POS) begin
                    active <= 1'b0;
                    shreg  <= '1;
                end else begin
                    bitidx <= bitidx + IDX_W'(1);
                    shreg  <= {shreg[FRAME_BITS-2:0], 1'b1};
                end
            end
        end
    end
endmodule

// File: rtl/mdio_scan_master.sv
module mdio_scan_master
    import mdio_mgmt_pkg::*;
#(
    parameter int               DIV_W   = 8,
    parameter logic [DIV_W-1:0] DIV_RST = DIV_W'(4)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [15:0]       cfg_wdata,
    input  logic              mdio_in,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic [15:0]       rd_data,
    output logic              busy,
    output logic              scan_invalid,
    output logic              link_fail
);
    logic [DIV_W-1:0]  div_q;
    logic [ADDR_W-1:0] phy_q;
    logic [ADDR_W-1:0] reg_q;
    logic [DATA_W-1:0] txd_q;
    logic              scan_en;
    logic              pend_wr;
    logic              pend_rd;
    kind_e             kind_q;
    kind_e             next_kind;
    frame_req_t        req;
    logic              start;
    logic              eng_active;
    logic              eng_done;
    logic              rise_t;
    logic              fall_t;
    logic [DATA_W-1:0] eng_rx;

    assign busy = eng_active | pend_wr | pend_rd | scan_en;

    always_comb begin
        start     = 1'b0;
        next_kind = K_READ;
        req       = '{op: OP_READ, phy: phy_q, regad: reg_q, data: txd_q};
        if (!eng_active) begin
            if (pend_wr) begin
                start     = 1'b1;
                next_kind = K_WRITE;
                req.op    = OP_WRITE;
            end else if (pend_rd) begin
                start     = 1'b1;
                next_kind = K_READ;
            end else if (scan_en) begin
                start     = 1'b1;
                next_kind = K_SCAN;
                req.regad = STAT_REG;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q        <= DIV_RST;
            phy_q        <= '0;
            reg_q        <= '0;
            txd_q        <= '0;
            scan_en      <= 1'b0;
            pend_wr      <= 1'b0;
            pend_rd      <= 1'b0;
            kind_q       <= K_READ;
            rd_data      <= '0;
            scan_invalid <= 1'b0;
            link_fail    <= 1'b0;
        end else begin
            if (start) begin
                pend_wr <= 1'b0;
                pend_rd <= 1'b0;
                kind_q  <= next_kind;
            end
            if (eng_done) begin
                if (kind_q != K_WRITE)
                    rd_data <= eng_rx;
                if (kind_q == K_SCAN) begin
                    link_fail    <= ~eng_rx[LINK_BIT];
                    scan_invalid <= 1'b0;
                end
            end
            if (cfg_wr) begin
                case (cfg_sel)
                    SEL_DIV:  div_q <= cfg_wdata[DIV_W-1:0];
                    SEL_CMD: begin
                        scan_en <= cfg_wdata[CMD_SCAN];
                        if (cfg_wdata[CMD_SCAN] && !scan_en)
                            scan_invalid <= 1'b1;
                        if (!busy) begin
                            pend_wr <= cfg_wdata[CMD_WR];
                            pend_rd <= cfg_wdata[CMD_RD] && !cfg_wdata[CMD_WR];
                        end
                    end
                    SEL_ADDR: begin
                        phy_q <= cfg_wdata[ADDR_W-1:0];
                        reg_q <= cfg_wdata[8 +: ADDR_W];
                    end
                    default:  txd_q <= cfg_wdata;
                endcase
            end
        end
    end

    mdc_gen #(.DIV_W(DIV_W)) u_mdc (
        .clk       (clk),
        .rst       (rst),
        .run       (eng_active),
        .div       (div_q),
        .mdc       (mdc),
        .rise_tick (rise_t),
        .fall_tick (fall_t)
    );

    mdio_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .req       (req),
        .rise_tick (rise_t),
        .fall_tick (fall_t),
        .mdio_in   (mdio_in),
        .active    (eng_active),
        .done      (eng_done),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe),
        .rx_data   (eng_rx)
    );
endmodule

// File: rtl/mdio_scan_master_chk.sv
module mdio_scan_master_chk (
    input logic        clk,
    input logic        rst,
    input logic        mdc,
    input logic        mdio_out,
    input logic        mdio_oe,
    input logic        busy,
    input logic        scan_invalid,
    input logic        link_fail,
    input logic [15:0] rd_data
);
    a_r11_drive_on_low: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> ($stable(mdio_out) && $stable(mdio_oe)));

    a_r2_mdc_idle_low: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

    a_r9_busy_ends_with_frame: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $fell(mdc));

    a_r8_invalid_only_busy: assert property (@(posedge clk) disable iff (rst)
        scan_invalid |-> busy);

    a_r7_link_at_frame_end: assert property (@(posedge clk) disable iff (rst)
        !$stable(link_fail) |-> $fell(mdc));

    a_r4_rd_at_frame_end: assert property (@(posedge clk) disable iff (rst)
        !$stable(rd_data) |-> $fell(mdc));
endmodule

bind mdio_scan_master mdio_scan_master_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .mdc          (mdc),
    .mdio_out     (mdio_out),
    .mdio_oe      (mdio_oe),
    .busy         (busy),
    .scan_invalid (scan_invalid),
    .link_fail    (link_fail),
    .rd_data      (rd_data)
);

// File: tb/mdio_scan_master_bench.sv
`timescale 1ns/1ps
module mdio_scan_master_bench;
    localparam int PA = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        mdio_in = 1'b1;
    logic        mdc, mdio_out, mdio_oe, busy, scan_invalid, link_fail;
    logic [15:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    mdio_scan_master u_mdio_scan_master (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .mdio_in(mdio_in), .mdc(mdc),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .rd_data(rd_data),
        .busy(busy), .scan_invalid(scan_invalid), .link_fail(link_fail)
    );

    // PHY model
    logic [15:0] phy_mem [32];
    logic        link = 1'b1;
    int          pos = 0, ones = 0, f_ones = 0;
    int          frames = 0, wr_frames = 0, oe_err = 0, per = 0;
    logic [63:0] fr = '1;
    logic [1:0]  f_op, f_ta;
    logic [4:0]  f_phy, f_reg;
    logic [15:0] f_data, rdval;
    longint      t_last = 0;

    function automatic logic [15:0] exp_reg(input int r);
        if (r == 1) return (phy_mem[1] & 16'hFFFB) | {13'd0, link, 2'd0};
        return phy_mem[r];
    endfunction

    initial for (int i = 0; i < 32; i++) phy_mem[i] = 16'h1000 + 16'(i) * 16'h0111;

    always @(posedge mdc) begin
        logic b;
        b = mdio_oe ? mdio_out : mdio_in;
        if (t_last > 0) per = int'(($time - t_last) / 20);
        t_last = $time;
        if (pos == 0) begin
            if (b) ones++;
            else if (ones >= 32) begin
                f_ones = ones; fr = '1; fr[31] = 1'b0; pos = 33;
            end else ones = 0;
        end else begin
            fr[63 - pos] = b;
            if (pos >= 36) begin
                if (fr[29:28] == 2'b10 && pos >= 46 && mdio_oe) oe_err++;
                if (fr[29:28] == 2'b01 && !mdio_oe) oe_err++;
            end
            pos++;
            if (pos == 64) begin
                f_op = fr[29:28]; f_phy = fr[27:23]; f_reg = fr[22:18];
                f_ta = fr[17:16]; f_data = fr[15:0];
                frames++;
                if (f_op == 2'b01 && f_phy == 5'(PA)) begin
                    phy_mem[f_reg] = f_data; wr_frames++;
                end
                pos = 0; ones = 0; mdio_in = 1'b1;
            end else if (fr[29:28] == 2'b10 && fr[27:23] == 5'(PA) && pos >= 47) begin
                if (pos == 47) begin
                    rdval = exp_reg(int'(fr[22:18])); mdio_in = 1'b0;
                end else mdio_in = rdval[63 - pos];
            end
        end
    end

    // R11 monitor at the ports
    int r11_err = 0;
    logic p_mdc = 0, p_out = 1, p_oe = 0;
    always @(negedge clk) begin
        if (mdc && p_mdc && (mdio_out !== p_out || mdio_oe !== p_oe)) r11_err++;
        p_mdc = mdc; p_out = mdio_out; p_oe = mdio_oe;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic wait_idle();
        int g = 0;
        while (busy && g < 20000) begin @(negedge clk); g++; end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        #3_000_000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            summary();
            $finish;
        end
    end

    initial begin
        int ep, fsnap, wsnap;
        logic [15:0] m5;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !scan_invalid && !link_fail && !mdc && !mdio_oe, "R1 flags",
            {busy, scan_invalid, link_fail, mdc, mdio_oe}, 0);
        chk(rd_data == 16'h0, "R1 rd_data", rd_data, 0);

        // R2/R3: divisor sweep with write frames
        foreach (ep_list[k]) begin
            logic [15:0] d;
            d = 16'hC35A ^ 16'(k * 16'h0F0F);
            host_wr(2'd0, 16'(ep_list[k]));
            host_wr(2'd2, {3'd0, 5'(k + 2), 3'd0, 5'(PA)});
            host_wr(2'd3, d);
            host_wr(2'd1, 16'h0001);
            wait_idle();
            ep = (ep_list[k] & ~1) < 2 ? 2 : (ep_list[k] & ~1);
            chk(per == ep, "R2 mdc period", per, ep);
            chk(f_op == 2'b01 && f_ta == 2'b10 && f_ones == 32, "R3 op/ta/preamble",
                {f_ones, f_op, f_ta}, {32'd32, 2'b01, 2'b10});
            chk(f_phy == 5'(PA) && f_reg == 5'(k + 2), "R3 addresses", {f_phy, f_reg}, {5'(PA), 5'(k + 2)});
            chk(f_data == d && phy_mem[k + 2] == d, "R3 data", f_data, d);
            chk(!mdc, "R2 mdc low idle", mdc, 0);
        end
        host_wr(2'd0, 16'd2);

        // R3 write sweep over all registers
        for (int r = 0; r < 32; r++) begin
            logic [15:0] d;
            d = 16'hA5C3 ^ 16'(r * 16'h1357);
            host_wr(2'd2, {3'd0, 5'(r), 3'd0, 5'(PA)});
            host_wr(2'd3, d);
            host_wr(2'd1, 16'h0001);
            wait_idle();
            chk(phy_mem[r] == d, "R3 write sweep", phy_mem[r], d);
        end

        // R4 read sweep
        link = 1'b1;
        for (int r = 0; r < 32; r++) begin
            host_wr(2'd2, {3'd0, 5'(r), 3'd0, 5'(PA)});
            host_wr(2'd1, 16'h0002);
            wait_idle();
            chk(rd_data == exp_reg(r) && f_op == 2'b10, "R4 read", rd_data, exp_reg(r));
        end
        chk(oe_err == 0, "R4 oe release", oe_err, 0);

        // R5 absent PHY
        for (int p = 0; p < 32; p += 7) begin
            if (p == PA) continue;
            host_wr(2'd2, {3'd0, 5'd3, 3'd0, 5'(p)});
            host_wr(2'd1, 16'h0002);
            wait_idle();
            chk(rd_data == 16'hFFFF, "R5 no answer", rd_data, 16'hFFFF);
        end

        // R6/R7/R8 scan
        host_wr(2'd2, {3'd0, 5'd5, 3'd0, 5'(PA)});
        host_wr(2'd3, 16'h1234);
        m5 = phy_mem[5];
        wsnap = wr_frames;
        link = 1'b1;
        host_wr(2'd1, 16'h0004);
        chk(busy && scan_invalid, "R8 invalid on start", {busy, scan_invalid}, 3);
        for (int g = 0; g < 2000 && scan_invalid; g++) @(negedge clk);
        chk(!scan_invalid, "R8 invalid clears", scan_invalid, 0);
        chk(!link_fail && rd_data == exp_reg(1), "R7 link up", {link_fail, rd_data}, {1'b0, exp_reg(1)});
        chk(f_op == 2'b10 && f_reg == 5'd1 && f_phy == 5'(PA), "R6 status read", {f_op, f_reg}, {2'b10, 5'd1});
        // R10 write command during scan
        host_wr(2'd1, 16'h0005);
        link = 1'b0;
        fsnap = frames;
        repeat (400) @(negedge clk);
        chk(frames >= fsnap + 3, "R6 back to back", frames - fsnap, 3);
        chk(link_fail && rd_data == exp_reg(1), "R7 link down", {link_fail, rd_data}, {1'b1, exp_reg(1)});
        // R9 stop mid-frame
        while (pos != 40) @(negedge clk);
        fsnap = frames;
        host_wr(2'd1, 16'h0000);
        chk(busy, "R9 busy holds", busy, 1);
        wait_idle();
        repeat (300) @(negedge clk);
        chk(frames == fsnap + 1 && !busy, "R9 last read only", frames - fsnap, 1);
        chk(phy_mem[5] == m5 && wr_frames == wsnap, "R10 write ignored", phy_mem[5], m5);

        // R8 restart
        host_wr(2'd1, 16'h0004);
        chk(scan_invalid, "R8 restart", scan_invalid, 1);
        host_wr(2'd1, 16'h0000);
        wait_idle();

        chk(r11_err == 0, "R11 drive timing", r11_err, 0);
        finished = 1;
        summary();
        $finish;
    end

    int ep_list[8] = '{0, 1, 2, 3, 4, 6, 7, 10};
endmodule